// File: doc/BRIEF.md
# Master audio serial port transmitter with TDM slotting

This block drives the transmit side of a two-channel digital audio serial link as the clock master. A single-cycle `tick` input sets the pace: every tick is half a bit-clock period. From these ticks the block builds the bit clock and the frame clock, and it shifts a left and a right sample onto the data line, most significant bit first. A new sample pair is taken through a ready/valid handshake at the start of every frame.

Software-facing configuration comes in on plain input pins and is copied into the block only at a frame boundary. The configuration selects the sample width (16, 20, 24 or 32 bits) and the frame layout (I2S, left-justified, right-justified or DSP). It also chooses the frame length: the minimum of two words per frame, or a fixed 256 bit clocks. Two further settings choose a one-bit pulse or a half-frame square wave for the frame clock, and set a bit offset that moves the data words later in the frame. An optional high-impedance mode drops the output enable on every bit that carries no sample data. Together with the offset, this lets several transmitters share one time-division multiplexed data wire.

Top module: `aud_ser_tx`

## Requirements
- R1: Width codes 0, 1, 2 and 3 on `cfg_wcode` select W = 16, 20, 24 and 32 bits. With `cfg_fixed256` low, a frame is N = 2W bit clocks. Each bit clock takes two ticks: `bclk` is low after the first tick of the bit and high after the second.
- R2: With `cfg_fixed256` high, a frame is N = 256 bit clocks for every width, and the bit counter never reaches N.
- R3: Each word is sent MSB first from the low W bits of its sample input. `dout` and `dout_oe` change only together with a falling `bclk` and stay stable while `bclk` is high.
- R4: Format code 1 (left-justified): the left word starts at bit O' and the right word at bit N/2+O'. As a square wave, `fclk` is high in bits 0 to N/2-1.
- R5: Format code 0 (I2S): the word positions are the same as in R4. As a square wave, `fclk` is high in bits N/2-1 to N-2 and low in all other bits, so each word's MSB comes one bit after an `fclk` edge and the left word is sent while `fclk` is low.
- R6: Format code 2 (right-justified): the left word fills bits N/2-W to N/2-1 and the right word fills bits N-W to N-1. The offset is ignored, and the square `fclk` follows R4.
- R7: Format code 3 (DSP): the left word starts at bit O' and the right word follows it directly at bit O'+W. As a square wave, `fclk` is high in bit N-1 and in bits 0 to N/2-2.
- R8: With `cfg_pulse` high, `fclk` is high for exactly one bit per frame: bit 0 for format codes 1 and 2, and bit N-1 for codes 0 and 3.
- R9: The effective offset O' is min(`cfg_offset`, N/2-W) for format codes 0 and 1, and min(`cfg_offset`, N-2W) for code 3.
- R10: With `cfg_hiz` high, `dout_oe` is low on every bit outside the two words. With `cfg_hiz` low, `dout_oe` is high on every bit of a running frame. `dout` is 0 outside the words in both cases.
- R11: `samp_ready` is high only during a tick that starts a frame. A transfer captures both samples. If `samp_valid` is low at that tick, the frame sends zeros in both words.
- R12: Configuration and sample inputs that change inside a frame have no effect until the next frame boundary.
- R13: After reset, `bclk`, `fclk`, `dout` and `dout_oe` are low until the first tick, and that tick starts the first frame. Outputs show the new state one clock after each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Half-bit-period advance pulse |
| cfg_wcode | input | 2 | Sample width code |
| cfg_fmt | input | 2 | Frame format code |
| cfg_fixed256 | input | 1 | Fixed 256-bit-clock frame when high |
| cfg_pulse | input | 1 | Frame clock as one-bit pulse when high |
| cfg_hiz | input | 1 | Drop output enable outside data bits |
| cfg_offset | input | 8 | Requested data start offset in bits |
| samp_valid | input | 1 | Sample pair offered |
| samp_ready | output | 1 | Sample pair accepted this cycle |
| samp_left | input | 32 | Left sample, low W bits used |
| samp_right | input | 32 | Right sample, low W bits used |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| dout | output | 1 | Serial data |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The delicate cycle is the tick that ends one frame and starts the next. In that single tick, the sample handshake, the capture of the new configuration and the counter wrap all happen together, and in I2S and DSP layouts the frame clock marks the frame's last bit at that same point. The bench provokes this on every frame. It holds the next configuration and samples on the pins up to the boundary tick, then scrambles them right after it, and it mixes frame lengths and formats from one frame to the next. It judges the boundary by checking that `samp_ready` is high only on that tick. It also checks, bit by bit, that the frame clock, the word positions and the output enable follow the configuration captured at the boundary and never the scrambled one.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int FIXED_BITS = 256;
  localparam int MAX_W      = 32;
  localparam int OFS_W      = 8;
  localparam int IDX_W      = $clog2(FIXED_BITS) + 1;
  localparam int SEL_W      = $clog2(MAX_W);

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [1:0]       wcode;
    fmt_e             fmt;
    logic             fixed256;
    logic             pulse;
    logic             hiz;
    logic [OFS_W-1:0] ofs;
  } cfg_t;

  // Sample width in bits for a width code.
  function automatic idx_t word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return idx_t'(16);
      2'd1:    return idx_t'(20);
      2'd2:    return idx_t'(24);
      default: return idx_t'(32);
    endcase
  endfunction

  // Bit clocks per frame.
  function automatic idx_t frame_bits(input cfg_t c);
    idx_t w;
    w = word_bits(c.wcode);
    if (c.fixed256) return idx_t'(FIXED_BITS);
    return w << 1;
  endfunction

  // Offset after clamping so that both words end inside the frame.
  function automatic idx_t eff_ofs(input cfg_t c);
    idx_t n;
    idx_t w;
    idx_t lim;
    idx_t req;
    n   = frame_bits(c);
    w   = word_bits(c.wcode);
    lim = (c.fmt == FMT_DSP) ? (n - (w << 1)) : ((n >> 1) - w);
    req = idx_t'(c.ofs);
    return (req > lim) ? lim : req;
  endfunction

  // First bit index of channel ch (0 = left, 1 = right).
  function automatic idx_t slot_start(input cfg_t c, input logic ch);
    idx_t n;
    idx_t w;
    idx_t o;
    n = frame_bits(c);
    w = word_bits(c.wcode);
    o = eff_ofs(c);
    case (c.fmt)
      FMT_RJ:  return ch ? (n - w) : ((n >> 1) - w);
      FMT_DSP: return ch ? (o + w) : o;
      default: return ch ? ((n >> 1) + o) : o;
    endcase
  endfunction

  // {inside word, data bit} for one channel at bit index b.
  function automatic logic [1:0] slot_probe(input cfg_t c, input logic ch,
                                            input idx_t b,
                                            input logic [MAX_W-1:0] s);
    idx_t             w;
    idx_t             st;
    idx_t             rel;
    logic [SEL_W-1:0] sel;
    logic             hit;
    w   = word_bits(c.wcode);
    st  = slot_start(c, ch);
    rel = b - st;
    hit = (b >= st) && (rel < w);
    sel = SEL_W'(w - idx_t'(1) - rel);
    return {hit, hit & s[sel]};
  endfunction

  // Frame clock level at bit index b.
  function automatic logic fclk_level(input cfg_t c, input idx_t b);
    idx_t n;
    idx_t h;
    logic last;
    logic early;
    n     = frame_bits(c);
    h     = n >> 1;
    last  = (b == n - idx_t'(1));
    early = (b < h - idx_t'(1));
    if (c.pulse) begin
      if (c.fmt == FMT_LJ || c.fmt == FMT_RJ) return b == idx_t'(0);
      return last;
    end
    case (c.fmt)
      FMT_LJ, FMT_RJ: return b < h;
      FMT_I2S:        return !(last || early);
      default:        return last || early;
    endcase
  endfunction

endpackage

// File: rtl/aud_ser_timer.sv
module aud_ser_timer
  import aud_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  idx_t frame_len,
  output logic run,
  output logic phase,
  output idx_t bit_idx,
  output logic frame_end
);

  logic last_bit;

  assign last_bit  = (bit_idx == frame_len - idx_t'(1));
  assign frame_end = tick && (!run || (phase && last_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      phase   <= 1'b0;
      bit_idx <= '0;
    end else if (tick) begin
      if (frame_end) begin
        run     <= 1'b1;
        phase   <= 1'b0;
        bit_idx <= '0;
      end else if (!phase) begin
        phase   <= 1'b1;
      end else begin
        phase   <= 1'b0;
        bit_idx <= bit_idx + idx_t'(1);
      end
    end
  end

endmodule

// File: rtl/aud_ser_capture.sv
module aud_ser_capture
  import aud_ser_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_end,
  input  cfg_t                     cfg_in,
  input  logic                     samp_valid,
  input  logic [MAX_W-1:0]         samp_left,
  input  logic [MAX_W-1:0]         samp_right,
  output cfg_t                     cfg_q,
  output logic [1:0][MAX_W-1:0]    samp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= cfg_t'('0);
      samp_q <= '0;
    end else if (frame_end) begin
      cfg_q     <= cfg_in;
      samp_q[0] <= samp_valid ? samp_left  : '0;
      samp_q[1] <= samp_valid ? samp_right : '0;
    end
  end

endmodule

// File: rtl/aud_ser_shifter.sv
module aud_ser_shifter
  import aud_ser_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  phase,
  input  idx_t                  bit_idx,
  input  cfg_t                  cfg_q,
  input  logic [1:0][MAX_W-1:0] samp_q,
  output logic                  word_active,
  output logic                  bclk,
  output logic                  fclk,
  output logic                  dout,
  output logic                  dout_oe
);

  logic [1:0][1:0] probe;
  logic            data_bit;

  for (genvar ch = 0; ch < 2; ch++) begin : g_slot
    assign probe[ch] = slot_probe(cfg_q, 1'(ch), bit_idx, samp_q[ch]);
  end

  assign word_active = probe[0][1] | probe[1][1];
  assign data_bit    = probe[0][0] | probe[1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk    <= 1'b0;
      fclk    <= 1'b0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      bclk    <= run & phase;
      fclk    <= run & fclk_level(cfg_q, bit_idx);
      dout    <= run & word_active & data_bit;
      dout_oe <= run & (word_active | !cfg_q.hiz);
    end
  end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       cfg_wcode,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_fixed256,
  input  logic             cfg_pulse,
  input  logic             cfg_hiz,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic             samp_valid,
  output logic             samp_ready,
  input  logic [MAX_W-1:0] samp_left,
  input  logic [MAX_W-1:0] samp_right,
  output logic             bclk,
  output logic             fclk,
  output logic             dout,
  output logic             dout_oe
);

  cfg_t                  cfg_in_w;
  cfg_t                  cur_cfg_w;
  logic [1:0][MAX_W-1:0] samp_w;
  idx_t                  frame_len_w;
  idx_t                  bit_idx_w;
  logic                  run_w;
  logic                  phase_w;
  logic                  frame_end_w;
  logic                  word_active_w;

  always_comb begin
    cfg_in_w.wcode    = cfg_wcode;
    cfg_in_w.fmt      = fmt_e'(cfg_fmt);
    cfg_in_w.fixed256 = cfg_fixed256;
    cfg_in_w.pulse    = cfg_pulse;
    cfg_in_w.hiz      = cfg_hiz;
    cfg_in_w.ofs      = cfg_offset;
  end

  assign frame_len_w = frame_bits(cur_cfg_w);
  assign samp_ready  = frame_end_w;

  aud_ser_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .frame_len (frame_len_w),
    .run       (run_w),
    .phase     (phase_w),
    .bit_idx   (bit_idx_w),
    .frame_end (frame_end_w)
  );

  aud_ser_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end_w),
    .cfg_in     (cfg_in_w),
    .samp_valid (samp_valid),
    .samp_left  (samp_left),
    .samp_right (samp_right),
    .cfg_q      (cur_cfg_w),
    .samp_q     (samp_w)
  );

  aud_ser_shifter u_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_w),
    .phase       (phase_w),
    .bit_idx     (bit_idx_w),
    .cfg_q       (cur_cfg_w),
    .samp_q      (samp_w),
    .word_active (word_active_w),
    .bclk        (bclk),
    .fclk        (fclk),
    .dout        (dout),
    .dout_oe     (dout_oe)
  );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk
  import aud_ser_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic samp_ready,
  input logic bclk,
  input logic dout,
  input logic dout_oe,
  input logic run,
  input logic frame_end,
  input idx_t bit_idx,
  input idx_t frame_len,
  input cfg_t cur_cfg
);

  AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ready |-> tick); // R11

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk && !dout_oe && !dout)); // R13

  AST_DATA_HOLD_BCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk && $past(bclk)) |-> ($stable(dout) && $stable(dout_oe))); // R3

  AST_CFG_FROZEN_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> $stable(cur_cfg)); // R12

  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_idx < frame_len)); // R2

  AST_COUNT_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(bit_idx)); // R1

endmodule

bind aud_ser_tx aud_ser_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .samp_ready (samp_ready),
  .bclk       (bclk),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .run        (run_w),
  .frame_end  (frame_end_w),
  .bit_idx    (bit_idx_w),
  .frame_len  (frame_len_w),
  .cur_cfg    (cur_cfg_w)
);

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  cfg_wcode = '0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_fixed256 = 1'b0;
  logic        cfg_pulse = 1'b0;
  logic        cfg_hiz = 1'b0;
  logic [7:0]  cfg_offset = '0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [31:0] samp_left = '0;
  logic [31:0] samp_right = '0;
  logic        bclk, fclk, dout, dout_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int fr = 0;
  int kk = 0;
  bit done = 1'b0;

  // Frame settings as captured at the last boundary (bench copy).
  int c_w, c_fmt, c_fix, c_pul, c_hiz, c_ofs;
  logic [31:0] c_left, c_right;

  always #4 clk = ~clk;

  aud_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_wcode(cfg_wcode), .cfg_fmt(cfg_fmt), .cfg_fixed256(cfg_fixed256),
    .cfg_pulse(cfg_pulse), .cfg_hiz(cfg_hiz), .cfg_offset(cfg_offset),
    .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_left(samp_left), .samp_right(samp_right),
    .bclk(bclk), .fclk(fclk), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (frame %0d tick %0d)",
               tag, act, exp, fr, kk);
    end
  endtask

  function automatic int wbits(input int code);
    int t[4] = '{16, 20, 24, 32};
    return t[code];
  endfunction

  function automatic int nbits();
    return (c_fix != 0) ? 256 : 2 * wbits(c_w);
  endfunction

  // Offset after clamp (R9).
  function automatic int ofs_used();
    int n = nbits();
    int w = wbits(c_w);
    int room = (c_fmt == 3) ? n - 2 * w : n / 2 - w;
    return (c_ofs < room) ? c_ofs : room;
  endfunction

  // Expected {bclk, fclk, oe, dout} after tick k of the frame.
  function automatic logic [3:0] expect_out(input int k);
    int b = k / 2;
    int n = nbits();
    int h = n / 2;
    int w = wbits(c_w);
    int o = ofs_used();
    int l0, r0;
    logic in_word, d, fc;
    case (c_fmt)
      2: begin l0 = h - w; r0 = n - w; end
      3: begin l0 = o;     r0 = o + w; end
      default: begin l0 = o; r0 = h + o; end
    endcase
    in_word = 1'b0; d = 1'b0;
    if (b >= l0 && b < l0 + w) begin in_word = 1'b1; d = c_left[w - 1 - (b - l0)]; end
    if (b >= r0 && b < r0 + w) begin in_word = 1'b1; d = c_right[w - 1 - (b - r0)]; end
    if (c_pul != 0)
      fc = (c_fmt == 1 || c_fmt == 2) ? (b == 0) : (b == n - 1);
    else if (c_fmt == 1 || c_fmt == 2)
      fc = (b < h);
    else if (c_fmt == 0)
      fc = (b >= h - 1) && (b <= n - 2);
    else
      fc = (b == n - 1) || (b < h - 1);
    return {logic'(k % 2), fc, in_word | (c_hiz == 0), d};
  endfunction

  task automatic do_tick(output logic rdy);
    @(negedge clk);
    tick = 1'b1;
    #1;
    rdy = samp_ready;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic string fmt_tag();
    string t[4] = '{"R5", "R4", "R6", "R7"};
    if (c_fmt != 2 && c_ofs > ofs_used()) return "R9";
    return t[c_fmt];
  endfunction

  task automatic run_frame(input int w, input int f, input int x, input int p,
                           input int hz, input int o, input bit v);
    logic rdy;
    logic [3:0] e;
    cfg_wcode = 2'(w); cfg_fmt = 2'(f); cfg_fixed256 = 1'(x);
    cfg_pulse = 1'(p); cfg_hiz = 1'(hz); cfg_offset = 8'(o);
    samp_left = $urandom; samp_right = $urandom; samp_valid = v;
    c_w = w; c_fmt = f; c_fix = x; c_pul = p; c_hiz = hz; c_ofs = o;
    c_left = v ? samp_left : 32'h0;    // R11: no transfer sends zeros
    c_right = v ? samp_right : 32'h0;
    for (int k = 0; k < 2 * nbits(); k++) begin
      kk = k;
      do_tick(rdy);
      if (k == 0) begin
        chk("R11 ready at boundary", rdy, 1'b1);
        // R12: scramble every input right after the boundary
        cfg_wcode = 2'($urandom); cfg_fmt = 2'($urandom);
        cfg_fixed256 = 1'($urandom); cfg_pulse = 1'($urandom);
        cfg_hiz = 1'($urandom); cfg_offset = 8'($urandom);
        samp_valid = 1'($urandom); samp_left = $urandom; samp_right = $urandom;
      end else if (k == 1) begin
        chk("R11 ready mid-frame", rdy, 1'b0);
      end
      e = expect_out(k);
      chk((c_fix != 0) ? "R2 bclk" : "R1 bclk", bclk, e[3]);
      chk("R8 fclk", fclk, e[2]);
      chk("R10 oe", dout_oe, e[1]);
      chk(fmt_tag(), dout, e[0]); // R3 MSB-first data, R12 old settings
    end
    fr++;
  endtask

  initial begin
    #(8 * 180000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13: quiet until the first tick
    chk("R13 bclk", bclk, 1'b0);
    chk("R13 fclk", fclk, 1'b0);
    chk("R13 dout", dout, 1'b0);
    chk("R13 oe", dout_oe, 1'b0);
    chk("R13 ready", samp_ready, 1'b0);

    run_frame(0, 1, 0, 0, 0, 0,   1'b1); // R4 16-bit
    run_frame(2, 0, 0, 0, 1, 5,   1'b1); // R5, R9 clamp to 0
    run_frame(1, 2, 1, 0, 1, 40,  1'b1); // R6 offset ignored, R2
    run_frame(3, 3, 0, 1, 0, 0,   1'b1); // R7, R8 pulse
    run_frame(3, 1, 1, 1, 1, 250, 1'b1); // R9 clamp to 96
    run_frame(1, 3, 1, 1, 1, 255, 1'b1); // R9 clamp to 216
    run_frame(0, 0, 1, 0, 1, 17,  1'b1); // R5 in fixed frame, R10
    run_frame(2, 2, 0, 0, 0, 0,   1'b0); // R11 underrun zeros

    for (int i = 0; i < 30; i++) begin
      run_frame(int'($urandom_range(3)), int'($urandom_range(3)),
                ($urandom_range(3) == 0) ? 1 : 0, int'($urandom_range(1)),
                int'($urandom_range(1)), int'($urandom_range(255)),
                ($urandom_range(7) != 0));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule